// File: doc/BRIEF.md
# Queue Error Interrupt and Auto-Disable Controller

This block serves one instruction queue. It gathers five event sources into a single interrupt line: a mailbox-written notice, doorbell overflow, an instruction read-response error, a result write-response error and an engine software error. Each source has a status bit that software clears by writing 1 and can raise for test by writing 1 to a set port. Each source also has an enable bit, with separate set and clear write ports. The interrupt output is asserted while any status bit and its enable are both 1.

The block also holds the queue enable bit and a continue-on-error control. Three of the events are fatal: doorbell overflow, read-response error and write-response error. When one of them is set and continue-on-error is 0, the queue enable drops on its own. This happens whether hardware raised the event or software injected it. An in-flight counter follows instructions between acceptance and completion. A quiescent flag tells software when the queue can safely be reconfigured.

Registers are reached through a single-cycle write port and a combinational read port that share one 3-bit address space.

Top module: `qerr_irq_ctrl`

## Requirements
- R1: After reset, status, enables, queue enable, continue-on-error and the in-flight count are all 0, irq_o is 0 and quiescent_o is 1.
- R2: Event bit positions are fixed, and evt_i uses the same indices. Bit 0 is mailbox written, bit 1 doorbell overflow, bit 2 instruction read-response error, bit 3 result write-response error and bit 4 engine software error. A 1 on evt_i[k] sets status bit k at that clock edge.
- R3: Address 0 reads the status bits in bits 4:0. Writing it clears each status bit whose data bit is 1.
- R4: Address 1 reads the status bits. Writing it sets each status bit whose data bit is 1.
- R5: Writing address 2 sets the enable bits that have a 1 in the data. Writing address 3 clears them. Reading either address returns the enables.
- R6: irq_o is 1 exactly when some status bit and its matching enable bit are both 1.
- R7: If a status bit is set (by evt_i or by the set port) in the same cycle that a clear write targets it, the bit ends up set.
- R8: With continue-on-error 0, any set of bit 1, 2 or 3 clears the queue enable at the same edge. The set may come from evt_i or from the set port. This takes priority over a software write to address 4 in that cycle.
- R9: With continue-on-error 1, no event changes the queue enable. Bits 0 and 4 never change it.
- R10: Address 4 holds the queue enable in bit 0 and continue-on-error in bit 1. Both are read/write, and queue_ena_o follows bit 0.
- R11: Address 5 and inflight_o give the in-flight count. accept_i increments it and done_i decrements it. Both in one cycle leave it unchanged. It saturates at 0 and at its maximum.
- R12: quiescent_o is 1 only when the queue enable is 0 and the in-flight count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| evt_i | input | 5 | Hardware event pulses, one per status bit |
| accept_i | input | 1 | Instruction accepted pulse |
| done_i | input | 1 | Instruction completed pulse |
| irq_o | output | 1 | Combined interrupt |
| queue_ena_o | output | 1 | Queue enable |
| quiescent_o | output | 1 | Queue disabled and empty |
| inflight_o | output | 8 | In-flight instruction count |

## Verification
A status or enable flop holding the wrong value shows up one edge after the stimulus. It appears on rd_data_o at address 0 or 2, and on irq_o when the matching enable or status bit is 1. A wrong queue-enable decision after a fatal event appears on queue_ena_o and quiescent_o in the cycle after the event edge. That includes clearing on a non-fatal bit, or ignoring continue-on-error. A miscounted in-flight value is visible at once on inflight_o. It keeps quiescent_o low until the count returns to zero, so an off-by-one error in the counter persists and stays observable.

// File: rtl/qerr_pkg.sv
package qerr_pkg;
  localparam int unsigned NUM_EVT = 5;
  localparam int unsigned ADDR_W  = 3;

  localparam int unsigned EVT_MBOX  = 0;
  localparam int unsigned EVT_DBOVF = 1;
  localparam int unsigned EVT_RDERR = 2;
  localparam int unsigned EVT_WRERR = 3;
  localparam int unsigned EVT_SWERR = 4;

  localparam logic [NUM_EVT-1:0] FATAL_MASK = 5'b01110;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT    = 3'd0,
    A_STATSET = 3'd1,
    A_ENSET   = 3'd2,
    A_ENCLR   = 3'd3,
    A_QCTL    = 3'd4,
    A_INFL    = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/qerr_evt_bit.sv
module qerr_evt_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,     // hardware or software set
  input  logic clr_i,     // software write-1-to-clear
  input  logic en_set_i,
  input  logic en_clr_i,
  output logic stat_o,
  output logic en_o
);
  logic stat_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (set_i)        stat_q <= 1'b1;
      else if (clr_i)   stat_q <= 1'b0;
      if (en_set_i)     en_q <= 1'b1;
      else if (en_clr_i) en_q <= 1'b0;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> stat_o);
  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !stat_o);
  a_r5_en_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_clr_i && !en_set_i) |=> !en_o);
endmodule

// File: rtl/qerr_qctl.sv
module qerr_qctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wr_ena_i,
  input  logic wr_cont_i,
  input  logic fatal_i,
  output logic ena_o,
  output logic cont_o
);
  logic ena_q, cont_q, kill;

  assign kill = fatal_i && !cont_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_q  <= 1'b0;
      cont_q <= 1'b0;
    end else begin
      if (wr_i) cont_q <= wr_cont_i;
      // auto-disable outranks a software enable in the same cycle
      if (kill)      ena_q <= 1'b0;
      else if (wr_i) ena_q <= wr_ena_i;
    end
  end

  assign ena_o  = ena_q;
  assign cont_o = cont_q;

  a_r8_auto_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fatal_i && !cont_o) |=> !ena_o);
  a_r9_cont_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cont_o && !wr_i) |=> $stable(ena_o));
endmodule

// File: rtl/qerr_inflight.sv
module qerr_inflight #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r11_both_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> $stable(cnt_o));
  a_r11_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && !inc_i) |=> cnt_o == '0);
endmodule

// File: rtl/qerr_irq_ctrl.sv
module qerr_irq_ctrl
  import qerr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [4:0]        evt_i,
  input  logic              accept_i,
  input  logic              done_i,
  output logic              irq_o,
  output logic              queue_ena_o,
  output logic              quiescent_o,
  output logic [CNT_W-1:0]  inflight_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_EVT;

  logic [NUM_EVT-1:0] wd, sw_set, sw_clr, en_set, en_clr, set_vec, stat, en;
  logic               fatal, qctl_wr, ena, cont;
  logic [CNT_W-1:0]   cnt;
  logic               unused_w;

  assign wd      = wr_data_i[NUM_EVT-1:0];
  assign unused_w = ^wr_data_i[DATA_W-1:NUM_EVT];
  assign sw_clr  = (wr_en_i && wr_addr_i == A_STAT)    ? wd : '0;
  assign sw_set  = (wr_en_i && wr_addr_i == A_STATSET) ? wd : '0;
  assign en_set  = (wr_en_i && wr_addr_i == A_ENSET)   ? wd : '0;
  assign en_clr  = (wr_en_i && wr_addr_i == A_ENCLR)   ? wd : '0;
  assign qctl_wr = wr_en_i && wr_addr_i == A_QCTL;
  assign set_vec = evt_i | sw_set;
  assign fatal   = |(set_vec & FATAL_MASK);

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    qerr_evt_bit u_bit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_vec[k]),
      .clr_i    (sw_clr[k]),
      .en_set_i (en_set[k]),
      .en_clr_i (en_clr[k]),
      .stat_o   (stat[k]),
      .en_o     (en[k])
    );
  end

  qerr_qctl u_qctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (qctl_wr),
    .wr_ena_i  (wr_data_i[0]),
    .wr_cont_i (wr_data_i[1]),
    .fatal_i   (fatal),
    .ena_o     (ena),
    .cont_o    (cont)
  );

  qerr_inflight #(.CNT_W(CNT_W)) u_infl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (accept_i),
    .dec_i  (done_i),
    .cnt_o  (cnt)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_STAT, A_STATSET: rd_data_o = {{PAD_W{1'b0}}, stat};
      A_ENSET, A_ENCLR:  rd_data_o = {{PAD_W{1'b0}}, en};
      A_QCTL:            rd_data_o = {{(DATA_W-2){1'b0}}, cont, ena};
      A_INFL:            rd_data_o = DATA_W'(cnt);
      default:           rd_data_o = '0;
    endcase
  end

  assign irq_o       = |(stat & en);
  assign queue_ena_o = ena;
  assign quiescent_o = !ena && cnt == '0;
  assign inflight_o  = cnt;

  a_r6_no_en_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o);
  a_r9_benign_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fatal && !qctl_wr) |=> $stable(queue_ena_o));
  a_r12_quiescent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiescent_o |-> (!queue_ena_o && inflight_o == '0));
endmodule

// File: tb/qerr_irq_ctrl_tb_top.sv
module qerr_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [4:0] evt = '0;
  logic       accept = 1'b0, done = 1'b0;
  logic       irq, qena, quiet;
  logic [7:0] infl;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct {
    int         kind;   // 0 rd_data, 1 irq, 2 queue_ena, 3 quiescent, 4 inflight
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  qerr_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .evt_i(evt), .accept_i(accept), .done_i(done), .irq_o(irq),
    .queue_ena_o(qena), .quiescent_o(quiet), .inflight_o(infl)
  );

  // monitor: samples 5 ns after each expectation is queued
  initial begin
    forever begin
      wait (sb.size() > 0);
      #5;
      begin
        item_t it;
        logic [7:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = rd_data;
          1: act = {7'd0, irq};
          2: act = {7'd0, qena};
          3: act = {7'd0, quiet};
          default: act = infl;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ev(input logic [4:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  task automatic ev_wr(input logic [4:0] m, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); evt = m; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); evt = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic acc, input logic dn);
    @(negedge clk); accept = acc; done = dn;
    @(negedge clk); accept = 1'b0; done = 1'b0;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk); rd_addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chk_out(input int k, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.kind = k; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_rd(0, 8'h00, "R1 status");
    chk_rd(2, 8'h00, "R1 enables");
    chk_rd(4, 8'h00, "R1 qctl");
    chk_out(4, 8'h00, "R1 inflight");
    chk_out(1, 8'h00, "R1 irq");
    chk_out(3, 8'h01, "R1 quiescent");
    // R10 enable queue
    wr(4, 8'h01);
    chk_out(2, 8'h01, "R10 queue_ena");
    chk_out(3, 8'h00, "R12 not quiescent when enabled");
    // R2 mailbox event, R9 benign bit
    ev(5'b00001);
    chk_rd(0, 8'h01, "R2 mailbox bit0");
    chk_out(1, 8'h00, "R6 irq masked");
    chk_out(2, 8'h01, "R9 mailbox keeps ena");
    // R5/R6 enable
    wr(2, 8'h01);
    chk_rd(3, 8'h01, "R5 enable read");
    chk_out(1, 8'h01, "R6 irq on");
    // R3 clear
    wr(0, 8'h01);
    chk_rd(0, 8'h00, "R3 w1c");
    chk_out(1, 8'h00, "R6 irq off");
    // engine sw error: not fatal
    ev(5'b10000);
    chk_rd(1, 8'h10, "R2 swerr bit4");
    chk_out(2, 8'h01, "R9 swerr keeps ena");
    wr(0, 8'h1F);
    // R8 hw fatal doorbell overflow
    ev(5'b00010);
    chk_rd(0, 8'h02, "R2 dbovf bit1");
    chk_out(2, 8'h00, "R8 hw fatal clears ena");
    // R8/R4 software injection
    wr(4, 8'h01);
    wr(1, 8'h08);
    chk_rd(0, 8'h0A, "R4 w1s");
    chk_out(2, 8'h00, "R8 sw inject clears ena");
    // R9 continue on error
    wr(0, 8'h1F);
    wr(4, 8'h03);
    ev(5'b00100);
    chk_rd(0, 8'h04, "R2 rderr bit2");
    chk_out(2, 8'h01, "R9 cont keeps ena");
    chk_rd(4, 8'h03, "R10 qctl readback");
    // R7 set beats clear
    wr(0, 8'h04);
    ev_wr(5'b00100, 0, 8'h04);
    chk_rd(0, 8'h04, "R7 set wins");
    // R5 clear / set other bits
    wr(3, 8'h01);
    chk_rd(2, 8'h00, "R5 en clear");
    wr(2, 8'h04);
    chk_out(1, 8'h01, "R6 irq bit2");
    wr(3, 8'h04);
    chk_out(1, 8'h00, "R6 irq after en clear");
    // R8 auto-disable beats software enable write
    wr(0, 8'h1F);
    wr(4, 8'h00);
    ev_wr(5'b01000, 4, 8'h01);
    chk_out(2, 8'h00, "R8 fatal over qctl write");
    chk_rd(0, 8'h08, "R2 wrerr bit3");
    // R11/R12 in-flight
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    chk_out(4, 8'h03, "R11 increments");
    chk_out(3, 8'h00, "R12 busy not quiescent");
    pulse(1, 1);
    chk_rd(5, 8'h03, "R11 both unchanged");
    pulse(0, 1); pulse(0, 1); pulse(0, 1);
    chk_out(4, 8'h00, "R11 decrements");
    chk_out(3, 8'h01, "R12 quiescent");
    pulse(0, 1);
    chk_out(4, 8'h00, "R11 saturate at zero");
    repeat (3) @(negedge clk);
    wait (sb.size() == 0);
    #10;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule